// File: doc/BRIEF.md
# Byte-Serial External Bus Master

This block sits between a simple single-request memory port and an 8-bit parallel external bus with a parity line in each direction. When a request is accepted, it sends a short packet one byte per clock: a command code, the address bytes and, for a write, a byte-select byte and the data bytes. It then watches the inbound lines for the far end's answer. A write finishes when the acknowledge code arrives. A read finishes once the acknowledge code and the eight following data bytes have been collected into a 64-bit word.

Only one transaction is in flight at a time. The far end may answer after any number of idle (all-zero) cycles, up to a parameterised timeout. A wrong answer code, a parity fault in the response or a timeout ends the request with an error indication. Parity is odd over the nine lines of each direction, so the parity line is the XNOR-reduction of the eight data lines. Every inbound byte with a wrong parity is reported on a separate flag.

Top module: `xbm_master`

## Requirements
- R1: After reset `bus_out` is 0x00 with `bus_out_par` 1, and `rsp_ack` and `par_err` are 0.
- R2: A read request accepted at a clock edge puts 0x02 on `bus_out` in the following cycle. The 4 address bytes follow on consecutive cycles, least significant first, and the bus then returns to 0x00.
- R3: A write request puts 0x03 on the bus, then the 4 address bytes least significant first, the select byte and the 8 data bytes least significant first, with no gaps. The bus then returns to 0x00.
- R4: In every cycle `bus_out_par` equals the XNOR-reduction of `bus_out`.
- R5: For a write, the edge that samples 0x83 on `bus_in` raises `rsp_ack` for exactly one cycle with `rsp_err` 0.
- R6: For a read, 0x82 followed by 8 data bytes (least significant first) raises `rsp_ack` for one cycle after the edge that samples the eighth byte. `rsp_rdata` then holds the assembled word and `rsp_err` is 0.
- R7: While waiting for the answer, 0x00 bytes are ignored and the bus stays at 0x00. The first nonzero byte is taken as the answer if it arrives on any of the first TIMEOUT_CYC sampling edges after the last request byte.
- R8: If the first nonzero inbound byte is not the expected code, `rsp_ack` pulses with `rsp_err` 1 after that edge and the block returns to idle.
- R9: If no nonzero byte arrives, `rsp_ack` pulses with `rsp_err` 1 after the TIMEOUT_CYC-th edge following the last request byte.
- R10: `par_err` is 1 in the cycle after every edge that samples `bus_in_par` different from the XNOR of `bus_in`. A read whose data byte has bad parity completes with `rsp_err` 1.
- R11: `req_valid` while a transaction is in flight is ignored: no command byte and no extra `rsp_ack` result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_sel | input | 8 | Byte select for writes |
| req_wdata | input | 64 | Write data |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion had an error (valid with rsp_ack) |
| rsp_rdata | output | 64 | Assembled read data |
| bus_out | output | 8 | Outbound bus byte |
| bus_out_par | output | 1 | Outbound parity |
| bus_in | input | 8 | Inbound bus byte |
| bus_in_par | input | 1 | Inbound parity |
| par_err | output | 1 | Inbound parity mismatch seen at the previous edge |

## Verification
The command byte is due one cycle after the accepting edge. Each further request byte follows exactly one cycle later. The completion pulse comes one register after the edge that samples the acknowledge (writes), the eighth data byte (reads) or the TIMEOUT_CYC-th waiting edge. `par_err` lags the sampled byte by one edge. The bench drives inbound bytes on falling edges and samples outputs 1 ns after each rising edge, counting edges from the last request byte. It sweeps the answer latency over every value from 0 to TIMEOUT_CYC-1 for both reads and writes.

// File: rtl/xbm_pkg.sv
package xbm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_SEL,
      ST_DATA,
      ST_WAIT,
      ST_RDATA
   } xbm_state_e;

   localparam logic [7:0] OP_READ  = 8'h02;
   localparam logic [7:0] OP_WRITE = 8'h03;
   localparam logic [7:0] ANS_READ  = 8'h82;
   localparam logic [7:0] ANS_WRITE = 8'h83;
endpackage

// File: rtl/xbm_parity.sv
module xbm_parity #(
   parameter int W   = 8,
   parameter bit ODD = 1'b1
) (
   input  logic [W-1:0] d,
   output logic         p
);
   generate
      if (ODD) begin : g_odd
         assign p = ~^d;
      end else begin : g_even
         assign p = ^d;
      end
   endgenerate
endmodule

// File: rtl/xbm_byte_pick.sv
module xbm_byte_pick #(
   parameter int W  = 64,
   parameter int BW = 8,
   parameter int IW = 3
) (
   input  logic [W-1:0]  word,
   input  logic [IW-1:0] idx,
   output logic [BW-1:0] lane
);
   localparam int LANES = W / BW;
   logic [BW-1:0] lanes [LANES];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lanes[g] = word[g*BW +: BW];
      end
   endgenerate

   always_comb begin
      lane = '0;
      for (int i = 0; i < LANES; i++)
         if (int'(idx) == i) lane = lanes[i];
   end
endmodule

// File: rtl/xbm_timer.sv
module xbm_timer #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/xbm_master.sv
module xbm_master #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 64,
   parameter int BUS_W       = 8,
   parameter int TIMEOUT_CYC = 64,
   parameter bit ODD_PARITY  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W/BUS_W-1:0] req_sel,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  rsp_ack,
   output logic                  rsp_err,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic [BUS_W-1:0]      bus_out,
   output logic                  bus_out_par,
   input  logic [BUS_W-1:0]      bus_in,
   input  logic                  bus_in_par,
   output logic                  par_err
);
   import xbm_pkg::*;

   localparam int ADDR_BYTES = ADDR_W / BUS_W;
   localparam int DATA_BYTES = DATA_W / BUS_W;
   localparam int SEL_W      = DATA_BYTES;
   localparam int MAX_BYTES  = (ADDR_BYTES > DATA_BYTES) ? ADDR_BYTES : DATA_BYTES;
   localparam int IDX_W      = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
   localparam logic [BUS_W-1:0] C_RD  = BUS_W'(OP_READ);
   localparam logic [BUS_W-1:0] C_WR  = BUS_W'(OP_WRITE);
   localparam logic [BUS_W-1:0] A_RD  = BUS_W'(ANS_READ);
   localparam logic [BUS_W-1:0] A_WR  = BUS_W'(ANS_WRITE);

   generate
      if ((ADDR_W % BUS_W) != 0 || (DATA_W % BUS_W) != 0) begin : g_bad_div
         $error("xbm_master: ADDR_W and DATA_W must be multiples of BUS_W");
      end
      if (BUS_W < 8) begin : g_bad_bus
         $error("xbm_master: BUS_W must hold the 8-bit codes");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_tmo
         $error("xbm_master: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   xbm_state_e         st;
   logic [IDX_W-1:0]   idx;
   logic               is_wr;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  wdata_q;
   logic [SEL_W-1:0]   sel_q;
   logic [BUS_W-1:0]   tx_q;
   logic [DATA_W-1:0]  rdata_q;
   logic               ack_q;
   logic               err_q;
   logic               perr_q;
   logic               acc_err;

   logic [BUS_W-1:0]   addr_lane;
   logic [BUS_W-1:0]   data_lane;
   logic               in_par_exp;
   logic               rx_bad;
   logic               expired;
   logic [BUS_W-1:0]   ans_exp;
   logic               addr_last;
   logic               data_last;

   xbm_byte_pick #(.W(ADDR_W), .BW(BUS_W), .IW(IDX_W)) u_addr_pick (
      .word(addr_q), .idx(idx), .lane(addr_lane));
   xbm_byte_pick #(.W(DATA_W), .BW(BUS_W), .IW(IDX_W)) u_data_pick (
      .word(wdata_q), .idx(idx), .lane(data_lane));

   xbm_parity #(.W(BUS_W), .ODD(ODD_PARITY)) u_tx_par (
      .d(tx_q), .p(bus_out_par));
   xbm_parity #(.W(BUS_W), .ODD(ODD_PARITY)) u_rx_par (
      .d(bus_in), .p(in_par_exp));

   xbm_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(st != ST_WAIT), .expired(expired));

   assign rx_bad    = (bus_in_par != in_par_exp);
   assign ans_exp   = is_wr ? A_WR : A_RD;
   assign addr_last = (idx == IDX_W'(ADDR_BYTES - 1));
   assign data_last = (idx == IDX_W'(DATA_BYTES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         idx     <= '0;
         is_wr   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         sel_q   <= '0;
         tx_q    <= '0;
         rdata_q <= '0;
         ack_q   <= 1'b0;
         err_q   <= 1'b0;
         perr_q  <= 1'b0;
         acc_err <= 1'b0;
      end else begin
         ack_q  <= 1'b0;
         perr_q <= rx_bad;
         tx_q   <= '0;
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  is_wr   <= req_write;
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  sel_q   <= req_sel;
                  tx_q    <= req_write ? C_WR : C_RD;
                  idx     <= '0;
                  acc_err <= 1'b0;
                  st      <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               tx_q <= addr_lane;
               if (addr_last) begin
                  idx <= '0;
                  st  <= is_wr ? ST_SEL : ST_WAIT;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_SEL: begin
               tx_q <= BUS_W'(sel_q);
               st   <= ST_DATA;
            end
            ST_DATA: begin
               tx_q <= data_lane;
               if (data_last) begin
                  idx <= '0;
                  st  <= ST_WAIT;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_WAIT: begin
               if (bus_in != '0) begin
                  if (bus_in == ans_exp && !rx_bad && !is_wr) begin
                     idx <= '0;
                     st  <= ST_RDATA;
                  end else begin
                     ack_q <= 1'b1;
                     err_q <= (bus_in != ans_exp) || rx_bad;
                     st    <= ST_IDLE;
                  end
               end else if (expired) begin
                  ack_q <= 1'b1;
                  err_q <= 1'b1;
                  st    <= ST_IDLE;
               end
            end
            ST_RDATA: begin
               rdata_q <= {bus_in, rdata_q[DATA_W-1:BUS_W]};
               if (rx_bad) acc_err <= 1'b1;
               if (data_last) begin
                  ack_q <= 1'b1;
                  err_q <= acc_err || rx_bad;
                  st    <= ST_IDLE;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign bus_out   = tx_q;
   assign rsp_ack   = ack_q;
   assign rsp_err   = err_q;
   assign rsp_rdata = rdata_q;
   assign par_err   = perr_q;
endmodule

// File: rtl/xbm_master_chk.sv
module xbm_master_chk #(
   parameter int BUS_W      = 8,
   parameter bit ODD_PARITY = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_write,
   input logic               rsp_ack,
   input logic [BUS_W-1:0]   bus_out,
   input logic [BUS_W-1:0]   bus_in,
   input logic               bus_in_par,
   input logic               par_err,
   input xbm_pkg::xbm_state_e st
);
   logic in_mismatch;
   assign in_mismatch = ODD_PARITY ? (bus_in_par == ^bus_in) : (bus_in_par != ^bus_in);

   // R2 R3
   cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && st == xbm_pkg::ST_IDLE) |=>
         (bus_out == ($past(req_write) ? BUS_W'(8'h03) : BUS_W'(8'h02))));

   // R5 R6
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ack |=> !rsp_ack);

   // R7
   quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ack |-> (bus_out == '0));

   // R10
   par_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_mismatch |=> par_err);

   // R11
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && st == xbm_pkg::ST_WAIT) |=> (st != xbm_pkg::ST_ADDR));
endmodule

bind xbm_master xbm_master_chk #(.BUS_W(BUS_W), .ODD_PARITY(ODD_PARITY)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .rsp_ack(rsp_ack), .bus_out(bus_out), .bus_in(bus_in),
   .bus_in_par(bus_in_par), .par_err(par_err), .st(st));

// File: tb/tb_xbm_master.sv
module tb_xbm_master;
   localparam int TMO = 12;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_write;
   logic [31:0] req_addr;
   logic [7:0]  req_sel;
   logic [63:0] req_wdata;
   logic        rsp_ack;
   logic        rsp_err;
   logic [63:0] rsp_rdata;
   logic [7:0]  bus_out;
   logic        bus_out_par;
   logic [7:0]  bus_in;
   logic        bus_in_par;
   logic        par_err;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   xbm_master #(.TIMEOUT_CYC(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_sel(req_sel), .req_wdata(req_wdata),
      .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .bus_out(bus_out), .bus_out_par(bus_out_par),
      .bus_in(bus_in), .bus_in_par(bus_in_par), .par_err(par_err));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] b, input bit bad);
      bus_in     = b;
      bus_in_par = bad ? ^b : ~^b;
   endtask

   task automatic out_byte(input string tag, input logic [7:0] exp);
      @(posedge clk); #1;
      chk(tag, bus_out, exp);
      chk("R4 out parity", bus_out_par, ~^bus_out);
   endtask

   // mode: 0 normal, 1 no answer, 2 bad parity on read byte 3, 3 request while busy
   task automatic run_txn(input bit wr, input logic [31:0] a, input logic [63:0] d,
                          input logic [7:0] s, input int lat, input logic [7:0] code,
                          input int mode);
      logic [7:0] expc;
      bit good;
      expc = wr ? 8'h83 : 8'h82;
      good = (code == expc);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_sel = s;
      @(posedge clk); #1;
      req_valid = 1'b0;
      chk(wr ? "R3 command" : "R2 command", bus_out, wr ? 64'h03 : 64'h02);
      chk("R4 out parity", bus_out_par, ~^bus_out);
      for (int k = 0; k < 4; k++) out_byte("R2 R3 address", a[8*k +: 8]);
      if (wr) begin
         out_byte("R3 select", s);
         for (int k = 0; k < 8; k++) out_byte("R3 data", d[8*k +: 8]);
      end
      if (mode == 1) begin
         for (int k = 1; k <= TMO; k++) begin
            @(posedge clk); #1;
            if (k == 1) chk("R7 bus quiet", bus_out, 0);
            if (k == TMO - 1) chk("R9 not yet", rsp_ack, 0);
            if (k == TMO) begin
               chk("R9 timeout ack", rsp_ack, 1);
               chk("R9 timeout err", rsp_err, 1);
            end
         end
      end else begin
         for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            req_valid = (mode == 3 && i == 0);
            req_write = 1'b0;
         end
         @(negedge clk);
         req_valid = 1'b0;
         drive(code, 1'b0);
         @(posedge clk); #1;
         if (wr || !good) begin
            chk("R5 R8 ack", rsp_ack, 1);
            chk("R5 R8 err", rsp_err, {63'd0, !good});
            @(negedge clk); drive(8'h00, 1'b0);
         end else begin
            chk("R6 no early ack", rsp_ack, 0);
            for (int k = 0; k < 8; k++) begin
               @(negedge clk);
               drive(d[8*k +: 8], mode == 2 && k == 3);
               @(posedge clk); #1;
               if (mode == 2 && k == 3) chk("R10 flag", par_err, 1);
            end
            chk("R6 ack", rsp_ack, 1);
            chk("R6 R10 err", rsp_err, (mode == 2) ? 64'd1 : 64'd0);
            chk("R6 rdata", rsp_rdata, d);
            @(negedge clk); drive(8'h00, 1'b0);
         end
         @(posedge clk); #1;
         chk("R5 R6 single pulse", rsp_ack, 0);
      end
      if (mode == 3) begin
         for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            chk("R11 no command", bus_out, 0);
            chk("R11 no ack", rsp_ack, 0);
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog act=hung exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_sel = '0; req_wdata = '0;
      drive(8'h00, 1'b0);
      repeat (3) @(posedge clk);
      #1;
      chk("R1 bus_out", bus_out, 0);
      chk("R1 parity", bus_out_par, 1);
      chk("R1 ack", rsp_ack, 0);
      chk("R1 par_err", par_err, 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 idle after release", bus_out, 0);

      // R10 standalone inbound parity fault
      @(negedge clk); drive(8'h00, 1'b1);
      @(posedge clk); #1; chk("R10 flag set", par_err, 1);
      @(negedge clk); drive(8'h00, 1'b0);
      @(posedge clk); #1; chk("R10 flag clear", par_err, 0);

      // latency sweep R5 R6 R7
      for (int lat = 0; lat < TMO; lat++) begin
         for (int w = 0; w < 2; w++) begin
            logic [31:0] a;
            logic [63:0] d;
            a = 32'h8000_0000 ^ (32'(lat) * 32'h0102_0304) ^ 32'(w);
            d = 64'h0102_0304_0506_0708 * 64'(lat + 1) ^ {32'(w), 32'(lat)};
            run_txn(w[0], a, d, 8'(8'hF0 >> lat), lat, w ? 8'h83 : 8'h82, 0);
         end
      end

      // R8 wrong answer codes
      run_txn(1'b0, 32'hDEAD_BEEF, 64'h1122_3344_5566_7788, 8'h00, 2, 8'h83, 0);
      run_txn(1'b1, 32'h0000_0001, 64'hFFEE_DDCC_BBAA_9988, 8'hA5, 1, 8'h55, 0);
      // R9 timeouts
      run_txn(1'b0, 32'h1234_5678, 64'h0, 8'h00, 0, 8'h00, 1);
      run_txn(1'b1, 32'h8765_4321, 64'hCAFE_F00D_0000_0001, 8'h3C, 0, 8'h00, 1);
      // R10 bad parity inside read data
      run_txn(1'b0, 32'h0F0F_0F0F, 64'hA1B2_C3D4_E5F6_0718, 8'h00, 3, 8'h82, 2);
      // R11 request while waiting
      run_txn(1'b1, 32'h5555_AAAA, 64'h0123_4567_89AB_CDEF, 8'hFF, 4, 8'h83, 3);
      // recovery read after error cases
      run_txn(1'b0, 32'h0000_00FF, 64'h8000_0000_0000_0001, 8'h00, 0, 8'h82, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule